// File: doc/BRIEF.md
# Match-compare system timer

This block is a free-running up-counter behind a small 32-bit register bus, with a compare register and an expiry interrupt. Software programs a compare value and a tick divider, then sets the enable bit. The counter advances once per selected number of clock cycles. When the count equals the compare value, the interrupt output pulses for one clock. With the clear-on-match option, the counter restarts from zero on the advance after a match, which gives a periodic tick. Without that option it runs on and wraps.

Writing any value to a dedicated clear offset zeroes the counter at any time. The divider code chooses one, two, three or four clock cycles per count. Its internal phase restarts whenever the divider code is written or the counter is cleared, so the first count after either event always waits a full divider period.

Top module: `match_timer`

## Requirements
- R1: After reset, the compare register reads all-ones over the counter width, the control register reads 0, the count reads 0, the divider code reads 0 and the interrupt is low.
- R2: Byte offsets are compare 0x00, count 0x04, control 0x08, clear 0x0C and divider 0x34. The counter advances only while control bit 0 (enable) is 1. While that bit is 0 the count holds its value.
- R3: While enabled with divider code n (bits [1:0] at 0x34, 0 to 3), the count advances once every n+1 clocks. Starting from phase 0, the count read k clocks after the clock that enabled it equals floor(k/(n+1)).
- R4: A write to the divider register or to the clear register restarts the divider phase. The next advance therefore comes a full n+1 enabled clocks later.
- R5: A write to offset 0x0C sets the count to 0 on that clock, whatever the write data. A clear takes precedence over an advance on the same clock.
- R6: When control bit 1 (clear-on-match) is 1 and an advance occurs while the count equals the compare value, the count becomes 0 instead of incrementing.
- R7: When clear-on-match is 0, the counter is CNT_W bits wide (default 32) and wraps from all-ones to 0.
- R8: The interrupt is high for exactly one clock: the first cycle in which the timer is enabled and the count equals the compare value. It stays low while that condition persists, and it fires again only after the condition has ended and later recurs.
- R9: A write to the compare register is used for comparison from the next clock onward.
- R10: Reads of the compare, control and divider registers return their stored values, zero-extended. Reads of the clear offset and of unmapped offsets return 0. Writes to the count offset have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every rising edge is one input tick |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset of the register access |
| busWe | input | 1 | Write strobe, sampled on the clock edge |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| expIrq | output | 1 | One-clock expiry pulse |

## Verification
A corrupted divider phase shows up as the count read at 0x04 stepping one or more clocks early or late. That error is visible within at most four cycles of the enable, a divider write or a clear. A wrong compare or clear-on-match path shows up on the next advance: the count fails to return to zero, or the interrupt pulse is missing, repeated or displaced. A stale edge-detect register shows up as a second pulse one clock after the first. The count is followed every cycle against a bench model, so any of these faults appears within one divider period of its cause.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  localparam int OFS_MATCH = 'h00;
  localparam int OFS_COUNT = 'h04;
  localparam int OFS_CTRL  = 'h08;
  localparam int OFS_CLEAR = 'h0C;
  localparam int OFS_DIV   = 'h34;
  localparam int DIV_W     = 2;

  typedef struct packed {
    logic clrCnt;
    logic divWr;
  } mt_strobe_t;
endpackage

// File: rtl/mt_ctrl.sv
module mt_ctrl
  import match_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  matchVal,
  output logic              enBit,
  output logic              comBit,
  output logic [DIV_W-1:0]  divCode,
  output mt_strobe_t        strobe
);
  logic selMatch, selCount, selCtrl, selClear, selDiv;

  always_comb begin
    selMatch = (busAddr == ADDR_W'(OFS_MATCH));
    selCount = (busAddr == ADDR_W'(OFS_COUNT));
    selCtrl  = (busAddr == ADDR_W'(OFS_CTRL));
    selClear = (busAddr == ADDR_W'(OFS_CLEAR));
    selDiv   = (busAddr == ADDR_W'(OFS_DIV));
  end

  always_comb begin
    strobe.clrCnt = busWe && selClear;
    strobe.divWr  = busWe && selDiv;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchVal <= '1;
      enBit    <= 1'b0;
      comBit   <= 1'b0;
      divCode  <= '0;
    end else if (busWe) begin
      if (selMatch) matchVal <= busWdata[CNT_W-1:0];
      if (selCtrl) begin
        enBit  <= busWdata[0];
        comBit <= busWdata[1];
      end
      if (selDiv) divCode <= busWdata[DIV_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (selMatch)      busRdata[CNT_W-1:0] = matchVal;
    else if (selCount) busRdata[CNT_W-1:0] = countVal;
    else if (selCtrl)  busRdata[1:0]       = {comBit, enBit};
    else if (selDiv)   busRdata[DIV_W-1:0] = divCode;
  end

  // R9
  match_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && selMatch) |=> (matchVal == $past(busWdata[CNT_W-1:0])));

  // R10
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && selCtrl) |=> ($stable(enBit) && $stable(comBit)));
endmodule

// File: rtl/mt_datapath.sv
module mt_datapath
  import match_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enBit,
  input  logic             comBit,
  input  logic [CNT_W-1:0] matchVal,
  input  logic [DIV_W-1:0] divCode,
  input  mt_strobe_t       strobe,
  output logic [CNT_W-1:0] countVal,
  output logic             expIrq
);
  logic [DIV_W-1:0] phase;
  logic             advance;
  logic             hit;
  logic             hitD;

  always_comb begin
    advance = enBit && (phase == divCode);
    hit     = enBit && (countVal == matchVal);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
      phase    <= '0;
      hitD     <= 1'b0;
    end else begin
      hitD <= hit;
      if (strobe.clrCnt)
        countVal <= '0;
      else if (advance)
        countVal <= (comBit && (countVal == matchVal)) ? '0 : countVal + 1'b1;
      if (strobe.clrCnt || strobe.divWr)
        phase <= '0;
      else if (enBit)
        phase <= advance ? '0 : phase + 1'b1;
    end
  end

  assign expIrq = hit && !hitD;

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    expIrq |=> !expIrq);

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> (countVal == '0));

  // R2
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enBit && !strobe.clrCnt) |=> $stable(countVal));

  // R7
  step_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($stable(countVal) || (countVal == '0) ||
              (countVal == $past(countVal) + 1'b1)));

  // R3
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && !strobe.divWr && !strobe.clrCnt) |=> (phase <= divCode));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              expIrq
);
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] matchVal;
  logic             enBit;
  logic             comBit;
  logic [DIV_W-1:0] divCode;
  mt_strobe_t       strobe;

  mt_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .countVal(countVal),
    .matchVal(matchVal), .enBit(enBit), .comBit(comBit),
    .divCode(divCode), .strobe(strobe)
  );

  mt_datapath #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .enBit(enBit), .comBit(comBit),
    .matchVal(matchVal), .divCode(divCode), .strobe(strobe),
    .countVal(countVal), .expIrq(expIrq)
  );
endmodule

// File: tb/test_match_timer.sv
module test_match_timer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 10;
  localparam logic [CNT_W-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic expIrq;

  int checks = 0;
  int errors = 0;
  bit modelOn = 1'b0;

  match_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_match_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .expIrq(expIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [CNT_W-1:0] mMatch, mCnt;
  logic mEn, mCom, mHitD;
  logic [1:0] mDiv, mPh;

  always @(posedge clk) begin
    logic adv, clr, dw, h;
    if (!rstN) begin
      mMatch = '1; mEn = 0; mCom = 0; mDiv = 0; mCnt = 0; mPh = 0; mHitD = 0;
    end else begin
      adv = mEn && (mPh == mDiv);
      h   = mEn && (mCnt == mMatch);
      clr = busWe && busAddr == 8'h0C;
      dw  = busWe && busAddr == 8'h34;
      mHitD = h;
      if (clr) mCnt = 0;
      else if (adv) mCnt = (mCom && mCnt == mMatch) ? '0 : mCnt + 1'b1;
      if (clr || dw) mPh = 0;
      else if (mEn) mPh = adv ? 2'd0 : mPh + 2'd1;
      if (busWe) begin
        case (busAddr)
          8'h00: mMatch = busWdata[CNT_W-1:0];
          8'h08: begin mEn = busWdata[0]; mCom = busWdata[1]; end
          8'h34: mDiv = busWdata[1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [DATA_W-1:0] modelRead(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] r = '0;
    case (a)
      8'h00: r[CNT_W-1:0] = mMatch;
      8'h04: r[CNT_W-1:0] = mCnt;
      8'h08: r[1:0] = {mCom, mEn};
      8'h34: r[1:0] = mDiv;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] expCount(input int k, input int n);
    return DATA_W'((k / (n + 1)) % (1 << CNT_W));
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // continuous comparison a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (modelOn) begin
      check("R2 R3 R4 R5 R6 R7 R10 read", busRdata, modelRead(busAddr));
      check("R8 irq", {31'b0, expIrq},
            {31'b0, (mEn && mCnt == mMatch && !mHitD)});
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = $urandom;
  endtask

  task automatic setRead(input logic [ADDR_W-1:0] a);
    busAddr = a;
    #1;
  endtask

  task automatic waitEdges(input int k);
    for (int i = 0; i < k; i++) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int irqCount;
    logic [DATA_W-1:0] held, maxSeen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    setRead(8'h00); check("R1 match", busRdata, DATA_W'(ALL1));
    setRead(8'h04); check("R1 count", busRdata, 0);
    setRead(8'h08); check("R1 ctrl", busRdata, 0);
    setRead(8'h34); check("R1 div", busRdata, 0);
    check("R1 irq", {31'b0, expIrq}, 0);
    modelOn = 1'b1;

    // R3 divide-by-3 timing from phase 0
    wr(8'h34, 32'd2);
    wr(8'h08, 32'd1);
    setRead(8'h04);
    waitEdges(11);
    check("R3 div3 count", busRdata, expCount(11, 2));

    // R2 hold while disabled
    wr(8'h08, 32'd0);
    setRead(8'h04);
    held = busRdata;
    waitEdges(10);
    check("R2 hold", busRdata, held);

    // R10 count write ignored, clear/unmapped read zero, div reads back
    wr(8'h04, 32'h155);
    setRead(8'h04); check("R10 count write ignored", busRdata, held);
    setRead(8'h0C); check("R10 clear reads 0", busRdata, 0);
    setRead(8'h10); check("R10 unmapped reads 0", busRdata, 0);
    setRead(8'h34); check("R10 div readback", busRdata, 2);

    // R5 clear with arbitrary data
    wr(8'h0C, 32'hDEAD_BEEF);
    setRead(8'h04); check("R5 clear", busRdata, 0);

    // R4 divider write restarts phase, divide-by-4
    wr(8'h34, 32'd3);
    wr(8'h08, 32'd1);
    setRead(8'h04);
    waitEdges(7);
    wr(8'h34, 32'd3);
    setRead(8'h04);
    held = busRdata;
    waitEdges(3);
    check("R4 phase restart no early step", busRdata, held);
    waitEdges(1);
    check("R4 phase restart step", busRdata, held + 1);

    // R7 wrap with clear-on-match off, div 1
    wr(8'h08, 32'd0);
    wr(8'h34, 32'd0);
    wr(8'h00, 32'd5);
    wr(8'h0C, 32'd0);
    wr(8'h08, 32'd1);
    setRead(8'h04);
    waitEdges(1030);
    check("R7 wrap", busRdata, expCount(1030, 0));

    // R6 clear-on-match, match=4
    wr(8'h08, 32'd0);
    wr(8'h0C, 32'd0);
    wr(8'h00, 32'd4);
    wr(8'h08, 32'd3);
    setRead(8'h04);
    maxSeen = 0;
    irqCount = 0;
    for (int i = 0; i < 30; i++) begin
      waitEdges(1);
      if (busRdata > maxSeen) maxSeen = busRdata;
      if (expIrq) irqCount++;
    end
    check("R6 max count", maxSeen, 4);
    check("R6 R8 irq per period", irqCount, 6);

    // R8 single pulse while count dwells at match (div 4)
    wr(8'h08, 32'd0);
    wr(8'h0C, 32'd0);
    wr(8'h34, 32'd3);
    wr(8'h00, 32'd7);
    wr(8'h08, 32'd1);
    irqCount = 0;
    for (int i = 0; i < 40; i++) begin
      waitEdges(1);
      if (expIrq) irqCount++;
    end
    check("R8 single pulse", irqCount, 1);

    // R9 compare write used next clock: set match to current count
    wr(8'h08, 32'd0);
    setRead(8'h04);
    held = busRdata;
    @(negedge clk);
    check("R9 no irq before write", {31'b0, expIrq}, 0);
    busAddr = 8'h00; busWe = 1'b1; busWdata = held;
    @(negedge clk);
    busWe = 1'b0;
    check("R9 disabled no irq", {31'b0, expIrq}, 0);
    wr(8'h08, 32'd1);
    check("R9 R8 irq on enable at match", {31'b0, expIrq}, 1);

    // random mix
    for (int it = 0; it < 3000; it++) begin
      int sel = $urandom_range(0, 19);
      case (sel)
        0: wr(8'h00, $urandom_range(0, 40));
        1: wr(8'h04, $urandom);
        2: wr(8'h08, $urandom_range(0, 3) | 1);
        3: wr(8'h0C, $urandom);
        4: wr(8'h34, $urandom);
        5: wr(8'h10, $urandom);
        6: wr(8'h08, $urandom_range(0, 3));
        default: begin
          @(negedge clk);
          busAddr = (sel < 16) ? 8'h04 : 8'(($urandom_range(0, 13)) * 4);
        end
      endcase
    end

    @(negedge clk);
    modelOn = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule